// File: doc/BRIEF.md
# Serial ADC Power-Mode Sequencer

This block is the host-side master for a serial analog-to-digital converter whose power state can only be changed through the chip-select and serial-clock pins. The converter has three power states: normal, partial power-down and full power-down. It drops one level deeper each time a frame is cut short by raising chip select early, after at least two falling serial-clock edges and before the tenth. A frame that keeps chip select low through the whole word wakes the converter back to normal. The sequencer takes a power-mode or conversion command on a request/acknowledge port. It then drives the frames needed to reach the requested state, waits out the converter's wake-up time where that is needed, and pulses the acknowledge.

After reset the converter's state is unknown. The first mode command therefore starts with a complete frame and then adds as many truncated frames as the target depth needs. After that first command the sequencer remembers the last state it commanded and uses the shortest path from there. A conversion command runs one complete frame and returns the received word with a one-cycle valid flag. Words clocked in during dummy frames are dropped.

Top module: `adc_pwr_seq`

## Requirements
- R1: While reset is applied and after it is released, `cs_n` and `sclk` are high and `ack` and `result_valid` are low. After reset the converter state is treated as unknown.
- R2: `req_op` encodes 0 = normal, 1 = partial power-down, 2 = full power-down, 3 = convert. From the unknown state, normal takes one complete frame, partial takes a complete frame then one truncated frame, and full takes a complete frame then two truncated frames.
- R3: A complete frame holds `cs_n` low for exactly FRAME_BITS falling `sclk` edges. `sclk` has a period of 2*DIV_HALF system clocks and is high whenever `cs_n` changes.
- R4: A truncated frame gives exactly TRUNC_EDGES falling edges, then raises `cs_n` half an `sclk` period later without sending any further edges. TRUNC_EDGES must lie between 2 and 9.
- R5: Between two frames, `cs_n` stays high for at least 2*DIV_HALF system clocks.
- R6: When the recorded state is known and the target is deeper, exactly one truncated frame is issued per level of depth and no complete frame is issued.
- R7: When the recorded state is known and the target is shallower, one complete frame is issued, followed by one truncated frame per level of the target's depth. When the target equals the recorded state, no frame is issued and `ack` still pulses.
- R8: When the target is normal and the previous state was full power-down or unknown, `ack` comes no earlier than PWRUP_CYCLES clocks after the last rise of `cs_n`. In every other case it comes fewer than PWRUP_CYCLES clocks after that rise.
- R9: A convert command runs one complete frame. The bit the converter presents after the k-th falling edge is sampled on the following rising edge, so the first bit sampled is the MSB of `result`. `result_valid` pulses once with the word, and the recorded state becomes normal.
- R10: Frames issued for mode changes never assert `result_valid`.
- R11: A request is accepted only when the sequencer is idle; a request made while busy has no effect. `ack` is a one-cycle pulse at the end of each accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Command request, sampled when idle |
| req_op | input | 2 | Command code (see R2) |
| ack | output | 1 | One-cycle pulse when a command has finished |
| sclk | output | 1 | Serial clock to the converter, idles high |
| cs_n | output | 1 | Active-low chip select to the converter |
| sdata | input | 1 | Serial data from the converter |
| result | output | FRAME_BITS | Last converted word |
| result_valid | output | 1 | One-cycle pulse with a new conversion word |

## Verification
The embedded assertions check on every cycle that each frame ends with the right number of falling edges for its kind and that no truncated frame goes past its limit. They also check the minimum chip-select-high gap, that `ack` lasts only one cycle, that `result_valid` only comes from conversion frames, and that a latched command does not change while busy. Only the bench's scenarios can show that the frame sequence chosen for each pair of starting state and target is correct, since that depends on the mode recorded across commands. The same holds for whether the wake-up wait is applied or skipped, and for whether the word assembled from the converter's bits comes out in MSB-first order.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [1:0] {
    OP_NORMAL  = 2'd0,
    OP_PARTIAL = 2'd1,
    OP_FULL    = 2'd2,
    OP_CONVERT = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    FR_IDLE, FR_LEAD, FR_LOW, FR_HIGH, FR_GAP
  } frame_st_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_LAUNCH, SQ_BUSY, SQ_PWAIT, SQ_DONE
  } seq_st_e;

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == CW'(HALF - 1));
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_frame.sv
module adc_frame
  import adc_pwr_pkg::*;
#(
  parameter int HALF  = 2,
  parameter int BITS  = 16,
  parameter int TRUNC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            full,
  input  logic            sdata,
  output logic            sclk,
  output logic            cs_n,
  output logic            done,
  output logic [BITS-1:0] rx_word
);

  localparam int EW  = $clog2(BITS + 1);
  localparam int GAP = 2 * HALF;
  localparam int GW  = $clog2(GAP + 1);

  frame_st_e       st_q, st_d;
  logic [EW-1:0]   edge_q, edge_d;
  logic            full_q, full_d;
  logic            gap_q, gap_d;
  logic [BITS-1:0] sh_q, sh_d;
  logic            tick;
  logic            run;

  assign run = (st_q != FR_IDLE);

  adc_sclk_div #(.HALF(HALF)) i_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  always_comb begin
    st_d   = st_q;
    edge_d = edge_q;
    full_d = full_q;
    gap_d  = gap_q;
    sh_d   = sh_q;
    unique case (st_q)
      FR_IDLE: if (start) begin
        st_d   = FR_LEAD;
        edge_d = '0;
        full_d = full;
        gap_d  = 1'b0;
      end
      FR_LEAD: if (tick) begin
        st_d   = FR_LOW;
        edge_d = edge_q + 1'b1;
      end
      FR_LOW: if (tick) begin
        if (!full_q && edge_q == EW'(TRUNC)) begin
          st_d  = FR_GAP;
          gap_d = 1'b0;
        end else begin
          st_d = FR_HIGH;
          sh_d = {sh_q[BITS-2:0], sdata};
        end
      end
      FR_HIGH: if (tick) begin
        if (edge_q == EW'(BITS)) begin
          st_d  = FR_GAP;
          gap_d = 1'b0;
        end else begin
          st_d   = FR_LOW;
          edge_d = edge_q + 1'b1;
        end
      end
      FR_GAP: if (tick) begin
        if (gap_q) st_d = FR_IDLE;
        else       gap_d = 1'b1;
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      edge_q <= '0;
      full_q <= 1'b1;
      gap_q  <= 1'b0;
      sh_q   <= '0;
    end else begin
      st_q   <= st_d;
      edge_q <= edge_d;
      full_q <= full_d;
      gap_q  <= gap_d;
      sh_q   <= sh_d;
    end
  end

  assign cs_n    = (st_q == FR_IDLE) || (st_q == FR_GAP);
  assign sclk    = (st_q != FR_LOW);
  assign done    = (st_q == FR_GAP) && tick && gap_q;
  assign rx_word = sh_q;

  // Cycles chip select has been high, saturating; used by the gap check.
  logic [GW-1:0] hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hi_q <= GW'(GAP);
    else if (!cs_n)               hi_q <= '0;
    else if (hi_q < GW'(GAP))     hi_q <= hi_q + 1'b1;
  end

  AST_FULL_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && full_q) |-> edge_q == EW'(BITS)); // R3
  AST_TRUNC_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && !full_q) |-> edge_q == EW'(TRUNC)); // R4
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !full_q) |-> edge_q <= EW'(TRUNC)); // R4
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_q >= GW'(GAP)); // R5

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int DIV_HALF     = 2,
  parameter int FRAME_BITS   = 16,
  parameter int TRUNC_EDGES  = 5,
  parameter int PWRUP_CYCLES = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [1:0]            req_op,
  output logic                  ack,
  output logic                  sclk,
  output logic                  cs_n,
  input  logic                  sdata,
  output logic [FRAME_BITS-1:0] result,
  output logic                  result_valid
);

  localparam int PW = $clog2(PWRUP_CYCLES + 1);

  logic rst_i_n;

  adc_rst_sync i_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_i_n)
  );

  seq_st_e               st_q, st_d;
  logic [1:0]            mode_q, mode_d;
  logic                  known_q, known_d;
  logic [1:0]            tgt_q, tgt_d;
  logic                  conv_q, conv_d;
  logic                  fleft_q, fleft_d;
  logic [1:0]            tleft_q, tleft_d;
  logic                  wait_q, wait_d;
  logic [PW-1:0]         pw_q, pw_d;
  logic [FRAME_BITS-1:0] res_q, res_d;
  logic                  val_q, val_d;
  logic                  fr_start, fr_full, fr_done;
  logic [FRAME_BITS-1:0] fr_word;

  adc_frame #(.HALF(DIV_HALF), .BITS(FRAME_BITS), .TRUNC(TRUNC_EDGES)) i_frame (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .start  (fr_start),
    .full   (fr_full),
    .sdata  (sdata),
    .sclk   (sclk),
    .cs_n   (cs_n),
    .done   (fr_done),
    .rx_word(fr_word)
  );

  always_comb begin
    st_d     = st_q;
    mode_d   = mode_q;
    known_d  = known_q;
    tgt_d    = tgt_q;
    conv_d   = conv_q;
    fleft_d  = fleft_q;
    tleft_d  = tleft_q;
    wait_d   = wait_q;
    pw_d     = pw_q;
    res_d    = res_q;
    val_d    = 1'b0;
    fr_start = 1'b0;
    fr_full  = 1'b1;
    unique case (st_q)
      SQ_IDLE: if (req) begin
        st_d = SQ_LAUNCH;
        if (req_op == OP_CONVERT) begin
          tgt_d   = OP_NORMAL;
          conv_d  = 1'b1;
          fleft_d = 1'b1;
          tleft_d = 2'd0;
          wait_d  = 1'b0;
        end else begin
          tgt_d  = req_op;
          conv_d = 1'b0;
          wait_d = (req_op == OP_NORMAL) && (!known_q || mode_q == OP_FULL);
          if (!known_q || req_op < mode_q) begin
            fleft_d = 1'b1;
            tleft_d = req_op;
          end else begin
            fleft_d = 1'b0;
            tleft_d = req_op - mode_q;
          end
        end
      end
      SQ_LAUNCH: begin
        if (fleft_q) begin
          fr_start = 1'b1;
          fleft_d  = 1'b0;
          st_d     = SQ_BUSY;
        end else if (tleft_q != 2'd0) begin
          fr_start = 1'b1;
          fr_full  = 1'b0;
          tleft_d  = tleft_q - 1'b1;
          st_d     = SQ_BUSY;
        end else if (wait_q) begin
          pw_d = '0;
          st_d = SQ_PWAIT;
        end else begin
          st_d = SQ_DONE;
        end
      end
      SQ_BUSY: if (fr_done) begin
        st_d = SQ_LAUNCH;
        if (conv_q) begin
          val_d = 1'b1;
          res_d = fr_word;
        end
      end
      SQ_PWAIT: begin
        if (pw_q == PW'(PWRUP_CYCLES - 1)) st_d = SQ_DONE;
        else                               pw_d = pw_q + 1'b1;
      end
      SQ_DONE: begin
        st_d    = SQ_IDLE;
        mode_d  = tgt_q;
        known_d = 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= SQ_IDLE;
      mode_q  <= OP_NORMAL;
      known_q <= 1'b0;
      tgt_q   <= OP_NORMAL;
      conv_q  <= 1'b0;
      fleft_q <= 1'b0;
      tleft_q <= 2'd0;
      wait_q  <= 1'b0;
      pw_q    <= '0;
      res_q   <= '0;
      val_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      mode_q  <= mode_d;
      known_q <= known_d;
      tgt_q   <= tgt_d;
      conv_q  <= conv_d;
      fleft_q <= fleft_d;
      tleft_q <= tleft_d;
      wait_q  <= wait_d;
      pw_q    <= pw_d;
      res_q   <= res_d;
      val_q   <= val_d;
    end
  end

  assign ack          = (st_q == SQ_DONE);
  assign result       = res_q;
  assign result_valid = val_q;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    ack |=> !ack); // R11
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q != SQ_IDLE) |=> ($stable(tgt_q) && $stable(conv_q))); // R11
  AST_VALID_CONV_ONLY: assert property (@(posedge clk) disable iff (!rst_i_n)
    result_valid |-> conv_q); // R10
  AST_WAKE_WAIT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ack && wait_q) |-> $past(st_q == SQ_PWAIT)); // R8

endmodule

// File: tb/test_adc_pwr_seq.sv
module test_adc_pwr_seq;

  localparam int H     = 2;
  localparam int BITS  = 16;
  localparam int TRUNC = 5;
  localparam int PWRUP = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic        ack, sclk, cs_n, result_valid;
  logic        sdata = 1'b0;
  logic [15:0] result;

  adc_pwr_seq #(.DIV_HALF(H), .FRAME_BITS(BITS), .TRUNC_EDGES(TRUNC), .PWRUP_CYCLES(PWRUP))
  i_adc_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op), .ack(ack),
    .sclk(sclk), .cs_n(cs_n), .sdata(sdata), .result(result), .result_valid(result_valid)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Results of the last command.
  int          fr_n, min_gap, vcnt, wait_cyc;
  int          fr_edges [4];
  logic        got_ack;
  logic [15:0] vword;
  logic [15:0] adc_word;

  // Vector fields: [9:8] op, [7:6] frames, [5:3] complete-frame mask, [2] wake wait, [1] conversion
  localparam logic [9:0] VEC [11] = '{
    {2'd2, 2'd3, 3'b001, 1'b0, 1'b0, 1'b0},  // unknown -> full
    {2'd0, 2'd1, 3'b001, 1'b1, 1'b0, 1'b0},  // full -> normal
    {2'd1, 2'd1, 3'b000, 1'b0, 1'b0, 1'b0},  // normal -> partial
    {2'd2, 2'd1, 3'b000, 1'b0, 1'b0, 1'b0},  // partial -> full
    {2'd1, 2'd2, 3'b001, 1'b0, 1'b0, 1'b0},  // full -> partial
    {2'd0, 2'd1, 3'b001, 1'b0, 1'b0, 1'b0},  // partial -> normal
    {2'd3, 2'd1, 3'b001, 1'b0, 1'b1, 1'b0},  // convert
    {2'd0, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0},  // normal -> normal
    {2'd2, 2'd2, 3'b000, 1'b0, 1'b0, 1'b0},  // normal -> full
    {2'd3, 2'd1, 3'b001, 1'b0, 1'b1, 1'b0},  // convert from full
    {2'd0, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0}   // state is normal after convert
  };
  localparam string TAGS [11] = '{"R2", "R8", "R6", "R6", "R7", "R7", "R9", "R7", "R6", "R9", "R9"};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input int inject);
    int   cyc = 0, last_rise = 0, edges = 0, hi = 0, bitk = 0;
    logic pcs, psc;
    @(negedge clk);
    pcs = cs_n; psc = sclk;
    fr_n = 0; min_gap = 1000; vcnt = 0; got_ack = 1'b0; vword = '0; wait_cyc = 0;
    req = 1'b1; req_op = op;
    while (!got_ack && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (cyc == inject) begin req = 1'b1; req_op = 2'd3; end
      else req = 1'b0;
      if (psc && !sclk && !cs_n) begin
        edges++; bitk++;
        sdata = (bitk <= 16) ? adc_word[16 - bitk] : 1'b0;
      end
      if (pcs && !cs_n) begin
        edges = 0; bitk = 0;
        if (fr_n > 0 && hi < min_gap) min_gap = hi;
      end
      if (!pcs && cs_n) begin
        if (fr_n < 4) fr_edges[fr_n] = edges;
        fr_n++;
        last_rise = cyc;
      end
      hi = cs_n ? hi + 1 : 0;
      if (result_valid) begin vcnt++; vword = result; end
      if (ack) begin got_ack = 1'b1; wait_cyc = cyc - last_rise; end
      pcs = cs_n; psc = sclk;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n && sclk && !ack && !result_valid, "R1 during reset", {cs_n, sclk, ack, result_valid}, 4'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n && sclk && !ack && !result_valid, "R1 after reset", {cs_n, sclk, ack, result_valid}, 4'b1100);
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();

    for (int i = 0; i < 11; i++) begin
      logic [1:0] op, n;
      logic [2:0] pat;
      logic       wt, cv;
      {op, n, pat, wt, cv} = VEC[i][9:1];
      adc_word = 16'hA5C3 ^ 16'(i * 16'h1357);
      run_cmd(op, 0);
      chk(got_ack, "R11 ack", got_ack, 1);
      chk(fr_n == n, TAGS[i], fr_n, n);
      for (int j = 0; j < n && j < 3; j++)
        if (pat[j]) chk(fr_edges[j] == BITS, "R3 complete edges", fr_edges[j], BITS);
        else        chk(fr_edges[j] == TRUNC, "R4 truncated edges", fr_edges[j], TRUNC);
      if (n > 1) chk(min_gap >= 2 * H, "R5 gap", min_gap, 2 * H);
      if (wt) chk(wait_cyc >= PWRUP, "R8 wake wait", wait_cyc, PWRUP);
      else    chk(wait_cyc < PWRUP, "R8 no wait", wait_cyc, PWRUP - 1);
      if (cv) begin
        chk(vcnt == 1, "R9 valid pulse", vcnt, 1);
        chk(vword == adc_word, "R9 word", vword, adc_word);
      end else begin
        chk(vcnt == 0, "R10 no valid", vcnt, 0);
      end
    end

    // R11: a request during a sequence is ignored (state is normal here)
    adc_word = 16'hFFFF;
    run_cmd(2'd2, 10);
    chk(fr_n == 2, "R11 busy cmd frames", fr_n, 2);
    chk(vcnt == 0, "R11 injected convert ignored", vcnt, 0);
    begin
      int extra = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (!cs_n || ack || result_valid) extra++;
      end
      chk(extra == 0, "R11 nothing after ack", extra, 0);
    end

    // R2: partial from unknown after a new reset
    do_reset();
    run_cmd(2'd1, 0);
    chk(fr_n == 2, "R2 partial from unknown", fr_n, 2);
    chk(fr_edges[0] == BITS && fr_edges[1] == TRUNC, "R2 partial shape", fr_edges[1], TRUNC);
    chk(wait_cyc < PWRUP, "R8 no wait into partial", wait_cyc, PWRUP - 1);

    // R2/R8: normal from unknown takes one complete frame and the wake wait
    do_reset();
    run_cmd(2'd0, 0);
    chk(fr_n == 1 && fr_edges[0] == BITS, "R2 normal from unknown", fr_n, 1);
    chk(wait_cyc >= PWRUP, "R8 wait from unknown", wait_cyc, PWRUP);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule